// File: doc/BRIEF.md
# Sequential Horner-Rule Fractional Multiplier

This block multiplies two W-bit two's complement fractions over W clock cycles. Both operands use a format whose binary point sits just below the sign bit: the top bit carries weight −1 and bit W−1−i carries weight 2^−i, so any operand lies between −1 and 1 − 2^−(W−1). The multiplier operand is consumed one bit per cycle, starting at its least significant bit. Each step adds either zero or a sign-extended copy of the multiplicand to a one-bit-wider accumulator, then halves the result with an arithmetic right shift. The step for the sign bit subtracts the multiplicand instead of adding it. It does this by adding the ones' complement of the multiplicand with a carry of one into the LSB, and it does not halve afterwards.

The exact product would be 2W−1 bits wide. Only its W most significant bits are returned, so the W−1 lowest bits are dropped, which is truncation toward minus infinity. The one product that does not fit, −1 × −1 = +1, is clamped to the largest positive value and flagged.

A caller raises `start_i` for one cycle with the operands valid. It then waits for the `done_o` pulse and reads `prod_o`, which stays valid until the next product completes.

Top module: `frac_horner_mul`

## Requirements
- R1: With operand integers a and b (each the W-bit pattern read as signed), `prod_o`, read as signed, equals floor(a·b / 2^(W−1)) for every operand pair except a = b = −2^(W−1).
- R2: A `start_i` high on a clock edge while `busy_o` is low captures both operands on that edge, and `busy_o` is high in the following cycle.
- R3: `busy_o` stays high for exactly W consecutive cycles per accepted start.
- R4: `done_o` is high for exactly one cycle, the first cycle in which `busy_o` is low again after a run.
- R5: `prod_o` changes only at the edge that raises `done_o`, and holds its value from then until the next completion.
- R6: When both operands equal −2^(W−1) (pattern 1 followed by zeros), `prod_o` is 2^(W−1)−1 (pattern 0 followed by ones) and `ovf_o` is high in the same cycle as `done_o`.
- R7: `ovf_o` is low for every other operand pair, and low in every cycle in which `done_o` is low.
- R8: A `start_i` high while `busy_o` is high is ignored: the run in progress keeps its operands and its cycle count.
- R9: After reset, `busy_o`, `done_o` and `ovf_o` are low and `prod_o` is zero.
- R10: A multiplier of −2^(W−1), which has only its sign bit set, gives floor(−a·2^(W−1) / 2^(W−1)) = −a for every multiplicand except −2^(W−1). This shows that the sign-bit step subtracts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a product; sampled only while idle |
| mcand_i | input | W | Multiplicand, signed fraction |
| mplier_i | input | W | Multiplier, signed fraction |
| busy_o | output | 1 | High while a product is being formed |
| done_o | output | 1 | One-cycle completion pulse |
| prod_o | output | W | Truncated, saturated product |
| ovf_o | output | 1 | Saturation flag, valid with `done_o` |

## Verification
The checker properties assume that `start_i` is a clean synchronous level, with no X or Z on it during or after reset. They do not assume that it is kept low while a run is in progress. The stimulus therefore raises `start_i` on purpose in the middle of some runs, so the properties on run length and output stability are exercised against starts that are ignored. Operands are only sampled on the start edge, so the stimulus scrambles the operand inputs right after each start. Every pair in a six-bit configuration is swept, which includes both extremes and zero.

// File: rtl/fhm_pkg.sv
`timescale 1ns/1ps
package fhm_pkg;

   typedef enum logic {
      FHM_IDLE = 1'b0,
      FHM_RUN  = 1'b1
   } fhm_state_e;

   // Width of a counter that must reach n-1.
   function automatic int unsigned fhm_cnt_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/fhm_sequencer.sv
`timescale 1ns/1ps
module fhm_sequencer #(
   parameter int unsigned STEPS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic last_o,
   output logic busy_o,
   output logic done_o
);
   import fhm_pkg::*;

   localparam int unsigned CW = fhm_cnt_w(STEPS);
   localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);

   fhm_state_e    state_q;
   logic [CW-1:0] idx_q;
   logic          done_q;

   assign busy_o = (state_q == FHM_RUN);
   assign load_o = (state_q == FHM_IDLE) && start_i;
   assign step_o = busy_o;
   assign last_o = busy_o && (idx_q == LAST_IDX);
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FHM_IDLE;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last_o;
         if (load_o) begin
            state_q <= FHM_RUN;
            idx_q   <= '0;
         end else if (last_o) begin
            state_q <= FHM_IDLE;
            idx_q   <= '0;
         end else if (busy_o) begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/fhm_horner_acc.sv
`timescale 1ns/1ps
module fhm_horner_acc #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         step_i,
   input  logic         last_i,
   input  logic [W-1:0] mcand_i,
   input  logic [W-1:0] mplier_i,
   output logic [W:0]   acc_nxt_o
);
   localparam int unsigned AW = W + 1;

   logic [W-1:0] a_q;
   logic [W-1:0] b_q;
   logic [AW-1:0] acc_q;
   logic [AW-1:0] a_ext;
   logic [AW-1:0] addend;
   logic [AW-1:0] sum;
   logic          cin;

   // One-bit sign extension of the multiplicand.
   assign a_ext  = {a_q[W-1], a_q};
   // Sign-bit step: ones' complement plus a carry into the LSB.
   assign addend = b_q[0] ? (last_i ? ~a_ext : a_ext) : '0;
   assign cin    = b_q[0] & last_i;
   assign sum    = acc_q + addend + AW'(cin);
   // Horner scaling by one half, skipped on the sign-bit step.
   assign acc_nxt_o = last_i ? sum : {sum[AW-1], sum[AW-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= '0;
         b_q   <= '0;
         acc_q <= '0;
      end else if (load_i) begin
         a_q   <= mcand_i;
         b_q   <= mplier_i;
         acc_q <= '0;
      end else if (step_i) begin
         b_q   <= b_q >> 1;
         acc_q <= acc_nxt_o;
      end
   end

endmodule

// File: rtl/fhm_trunc_sat.sv
`timescale 1ns/1ps
module fhm_trunc_sat #(
   parameter int unsigned W = 8
) (
   input  logic [W:0]   acc_i,
   output logic [W-1:0] res_o,
   output logic         ovf_o
);
   localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

   always_comb begin
      ovf_o = acc_i[W] ^ acc_i[W-1];
      if (!ovf_o)       res_o = acc_i[W-1:0];
      else if (acc_i[W]) res_o = MIN_NEG;
      else              res_o = MAX_POS;
   end

endmodule

// File: rtl/frac_horner_mul.sv
`timescale 1ns/1ps
module frac_horner_mul #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] mcand_i,
   input  logic [W-1:0] mplier_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] prod_o,
   output logic         ovf_o
);
   if (W < 2) begin : g_bad_width
      $error("frac_horner_mul: W must be at least 2");
   end

   logic         load, step, last;
   logic [W:0]   acc_nxt;
   logic [W-1:0] sat_res;
   logic         sat_ovf;
   logic [W-1:0] prod_q;
   logic         ovf_q;

   fhm_sequencer #(.STEPS(W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .load_o(load), .step_o(step), .last_o(last),
      .busy_o(busy_o), .done_o(done_o)
   );

   fhm_horner_acc #(.W(W)) u_acc (
      .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
      .last_i(last), .mcand_i(mcand_i), .mplier_i(mplier_i),
      .acc_nxt_o(acc_nxt)
   );

   fhm_trunc_sat #(.W(W)) u_sat (
      .acc_i(acc_nxt), .res_o(sat_res), .ovf_o(sat_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         ovf_q <= last & sat_ovf;
         if (last) prod_q <= sat_res;
      end
   end

   assign prod_o = prod_q;
   assign ovf_o  = ovf_q;

endmodule

// File: rtl/fhm_checker.sv
`timescale 1ns/1ps
module fhm_checker #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [W-1:0] prod_o,
   input logic         ovf_o
);
   localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

   int unsigned busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= 0;
      else        busy_run <= busy_o ? busy_run + 1 : 0;
   end

   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (busy_run == W));

   assert_done_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_prod_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(prod_o));

   assert_sat_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (prod_o == MAX_POS));

   assert_ovf_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> done_o);

endmodule

bind frac_horner_mul fhm_checker #(.W(W)) u_fhm_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
   .done_o(done_o), .prod_o(prod_o), .ovf_o(ovf_o)
);

// File: tb/frac_horner_mul_tb_top.sv
`timescale 1ns/1ps
module frac_horner_mul_tb_top;
   localparam int W    = 6;
   localparam int HALF = 1 << (W - 1);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] mcand = '0;
   logic [W-1:0] mplier = '0;
   logic         busy, done, ovf;
   logic [W-1:0] prod;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   frac_horner_mul #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mcand_i(mcand),
      .mplier_i(mplier), .busy_o(busy), .done_o(done),
      .prod_o(prod), .ovf_o(ovf)
   );

   task automatic check(input bit ok, input string req,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         summary();
      end
   end

   // One product; poke raises start mid-run (R8).
   task automatic run_mul(input int a, input int b, input bit poke);
      int cyc;
      int full;
      int expv;
      bit exp_ovf;
      logic [W-1:0] prev;
      full = a * b;
      expv = full >>> (W - 1);
      exp_ovf = (expv > HALF - 1);
      if (exp_ovf) expv = HALF - 1;
      @(negedge clk);
      mcand = W'(a); mplier = W'(b); start = 1'b1;
      @(negedge clk);
      start = 1'b0; mcand = ~W'(a); mplier = W'(b) ^ W'(5);
      check(busy === 1'b1, "R2 busy after start", longint'(busy), 1);
      cyc = 1;
      while (done !== 1'b1 && cyc < 4 * W) begin
         if (poke && cyc == 2) start = 1'b1;
         else start = 1'b0;
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      check(cyc == W + 1, "R3 cycles to done", cyc, W + 1);
      check(busy === 1'b0, "R4 busy low with done", longint'(busy), 0);
      if (a == -HALF && b == -HALF) begin
         check($signed(prod) == expv, "R6 saturated value", $signed(prod), expv);
         check(ovf === 1'b1, "R6 ovf raised", longint'(ovf), 1);
      end else begin
         if (b == -HALF)
            check($signed(prod) == -a, "R10 sign-bit subtract", $signed(prod), -a);
         check($signed(prod) == expv, poke ? "R8 start ignored" : "R1 product",
               $signed(prod), expv);
         check(ovf === 1'b0, "R7 ovf low", longint'(ovf), 0);
      end
      prev = prod;
      @(negedge clk);
      check(done === 1'b0, "R4 done one cycle", longint'(done), 0);
      check(ovf === 1'b0, "R7 ovf low without done", longint'(ovf), 0);
      mcand = W'(a + 3); mplier = W'(b + 1);
      repeat (2) @(negedge clk);
      check(prod === prev, "R5 result held", $signed(prod), $signed(prev));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy === 1'b0, "R9 busy reset", longint'(busy), 0);
      check(done === 1'b0, "R9 done reset", longint'(done), 0);
      check(ovf === 1'b0, "R9 ovf reset", longint'(ovf), 0);
      check(prod === '0, "R9 prod reset", longint'(prod), 0);
      rst_n = 1'b1;
      // corners first
      run_mul(-HALF, -HALF, 1'b0);
      run_mul(HALF - 1, HALF - 1, 1'b0);
      run_mul(-HALF, HALF - 1, 1'b1);
      run_mul(0, -HALF, 1'b0);
      // exhaustive sweep
      for (int ia = -HALF; ia < HALF; ia++) begin
         for (int ib = -HALF; ib < HALF; ib++) begin
            run_mul(ia, ib, ((ia + ib) % 7) == 0);
         end
      end
      summary();
   end

endmodule